// File: doc/BRIEF.md
# Pipelined Nonce Capture and Readout

This block drives a 32-bit trial value into a deep hashing pipeline, one new value per core clock cycle. It watches a single-bit match flag that returns from the far end of that pipeline, a fixed number of cycles later. When the flag is high, the block records which trial value produced the hit. A build-time parameter picks one of two capture modes. In the compensating mode the block subtracts the pipeline latency before storing. In the raw mode it stores the live counter, which keeps the subtractor off the capture path and leaves the correction to host software.

Stored hits go into a four-entry dual-clock queue. An external controller drains the queue on its own slower, unrelated clock, one byte per strobe over an 8-bit bus. Trial values that do not hit never leave the block. A synchronous load sets the counter's start value. For one pipeline depth after a load, match flags are ignored, because they belong to values issued before the load. When the queue is full, further hits are dropped and a sticky overflow flag is raised. The controller can clear that flag.

Top module: `nc_nonce_capture`

## Requirements
- R1: After reset, `issue_nonce` is 0, `rd_valid` is 0 and `ovf_flag` is 0.
- R2: `issue_nonce` increases by one (modulo 2^32) on each core clock edge while `hash_en` is high and `load_en` is low. It holds its value while `hash_en` is low.
- R3: A `load_en` pulse makes `issue_nonce` equal `load_value` on the next cycle. A match flag in any of the following PIPE_DEPTH-1 cycles is ignored. A match flag exactly PIPE_DEPTH cycles after the first cycle showing the loaded value is accepted.
- R4: In compensating mode, an accepted match stores `issue_nonce` (as seen in the match cycle) minus PIPE_DEPTH.
- R5: In raw mode, an accepted match stores `issue_nonce` as seen in the match cycle, unchanged.
- R6: `rd_data` shows byte 0 (bits 7:0) of the oldest entry first. Each `rd_strobe` cycle while `rd_valid` is high moves to the next more significant byte. The strobe on byte 3 removes the entry.
- R7: `rd_valid` is high exactly when the queue holds an entry. A strobe while `rd_valid` is low changes nothing.
- R8: The queue holds four entries. A match that arrives while it is full is discarded and sets `ovf_flag`, which stays set until cleared.
- R9: A one-cycle `ovf_clear` pulse in the read domain clears `ovf_flag` within a few read clock cycles.
- R10: Entries are read out in the order their matches arrived.
- R11: In compensating mode, the subtraction wraps modulo 2^32 when the counter is below PIPE_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Hashing core clock |
| core_rst | input | 1 | Synchronous active-high reset, core domain |
| hash_en | input | 1 | Counter advances while high |
| load_en | input | 1 | Load start value and blank pending matches |
| load_value | input | 32 | Start value for the counter |
| issue_nonce | output | 32 | Trial value sent to the pipeline this cycle |
| match_in | input | 1 | Hit flag from the pipeline output |
| rd_clk | input | 1 | Readout controller clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_strobe | input | 1 | Consume the current byte |
| rd_data | output | 8 | Current byte of the oldest stored hit |
| rd_valid | output | 1 | Queue holds at least one hit |
| ovf_flag | output | 1 | Sticky flag: a hit was lost because the queue was full |
| ovf_clear | input | 1 | Clears the overflow flag |

## Verification
The bench places a match on the last blanked cycle after a load and on the first accepted cycle. A design off by one in the blanking count would either store a stale value or lose a genuine hit. It loads a start value just below the 32-bit wrap, so a subtractor that saturated or used too narrow a width would return a wrong value. It issues five hits with no reads in between: a queue that overwrote instead of dropping would corrupt the oldest entry or report a fifth one. It also pulses strobes on an empty queue, which would skew the byte order if they were not ignored. Random start values and match delays are checked in both capture modes at once.

// File: rtl/nc_pkg.sv
package nc_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    CAPT_RAW       = 1'b0,
    CAPT_CORRECTED = 1'b1
  } capt_mode_e;
endpackage

// File: rtl/nc_nonce_gen.sv
module nc_nonce_gen #(
  parameter int NONCE_W    = 32,
  parameter int PIPE_DEPTH = 125
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hash_en,
  input  logic               load_en,
  input  logic [NONCE_W-1:0] load_value,
  output logic [NONCE_W-1:0] nonce,
  output logic               accept
);
  localparam int BW = $clog2(PIPE_DEPTH + 1);
  localparam logic [BW-1:0] BLANK_INIT = BW'(PIPE_DEPTH);
  localparam logic [NONCE_W-1:0] ONE = NONCE_W'(1);

  logic [BW-1:0] blank;

  always_ff @(posedge clk) begin
    if (rst) begin
      nonce <= '0;
    end else if (load_en) begin
      nonce <= load_value;
    end else if (hash_en) begin
      nonce <= nonce + ONE;
    end
  end

  // Matches still in flight from before a load (or reset) are masked.
  always_ff @(posedge clk) begin
    if (rst || load_en) begin
      blank <= BLANK_INIT;
    end else if (blank != '0) begin
      blank <= blank - 1'b1;
    end
  end

  assign accept = (blank == '0) && !load_en;

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (hash_en && !load_en) |=> (nonce == $past(nonce) + ONE));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!hash_en && !load_en) |=> $stable(nonce));
  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (nonce == $past(load_value)));
endmodule

// File: rtl/nc_capture.sv
module nc_capture import nc_pkg::*; #(
  parameter int         NONCE_W    = 32,
  parameter int         PIPE_DEPTH = 125,
  parameter capt_mode_e MODE       = CAPT_CORRECTED
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               match,
  input  logic               accept,
  input  logic [NONCE_W-1:0] nonce,
  output logic               cap_valid,
  output logic [NONCE_W-1:0] cap_data
);
  localparam logic [NONCE_W-1:0] DEPTH_W = NONCE_W'(PIPE_DEPTH);

  logic [NONCE_W-1:0] adj;

  generate
    if (MODE == CAPT_CORRECTED) begin : g_sub
      assign adj = nonce - DEPTH_W;
    end else begin : g_raw
      assign adj = nonce;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_valid <= 1'b0;
    end else begin
      cap_valid <= match && accept;
    end
  end

  always_ff @(posedge clk) begin
    if (match && accept) begin
      cap_data <= adj;
    end
  end
endmodule

// File: rtl/nc_async_fifo.sv
module nc_async_fifo #(
  parameter int W  = 32,
  parameter int AW = 2
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rclk,
  input  logic         rrst,
  input  logic         rd_pop,
  output logic [W-1:0] rd_word,
  output logic         empty
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wbin, wgray, wbin_nxt;
  logic [AW:0]  rbin, rgray, rbin_nxt;
  logic [AW:0]  rsync1, rsync2, wsync1, wsync2;

  // Write side
  assign full     = (wgray == {~rsync2[AW:AW-1], rsync2[AW-2:0]});
  assign wbin_nxt = wbin + {{AW{1'b0}}, (wr_en && !full)};

  always_ff @(posedge wclk) begin
    if (wr_en && !full) begin
      mem[wbin[AW-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin   <= '0;
      wgray  <= '0;
      rsync1 <= '0;
      rsync2 <= '0;
    end else begin
      wbin   <= wbin_nxt;
      wgray  <= wbin_nxt ^ (wbin_nxt >> 1);
      rsync1 <= rgray;
      rsync2 <= rsync1;
    end
  end

  // Read side
  assign empty    = (rgray == wsync2);
  assign rbin_nxt = rbin + {{AW{1'b0}}, (rd_pop && !empty)};

  always_ff @(posedge rclk) begin
    rd_word <= mem[rbin_nxt[AW-1:0]];
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin   <= '0;
      rgray  <= '0;
      wsync1 <= '0;
      wsync2 <= '0;
    end else begin
      rbin   <= rbin_nxt;
      rgray  <= rbin_nxt ^ (rbin_nxt >> 1);
      wsync1 <= wgray;
      wsync2 <= wsync1;
    end
  end

  assert_wgray_step_R10: assert property (@(posedge wclk) disable iff (wrst)
    $onehot0(wgray ^ $past(wgray)));
  assert_rgray_step_R10: assert property (@(posedge rclk) disable iff (rrst)
    $onehot0(rgray ^ $past(rgray)));
  assert_drop_full_R8: assert property (@(posedge wclk) disable iff (wrst)
    (wr_en && full) |=> $stable(wgray));
endmodule

// File: rtl/nc_byte_reader.sv
module nc_byte_reader import nc_pkg::*; #(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              empty,
  input  logic [W-1:0]      word,
  output logic              pop,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int NBYTES = W / BYTE_W;
  localparam int IW     = $clog2(NBYTES);
  localparam logic [IW-1:0] LAST = IW'(NBYTES - 1);

  logic [IW-1:0]     idx;
  logic [BYTE_W-1:0] lane [NBYTES];

  generate
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      assign lane[g] = word[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  assign pop      = strobe && !empty && (idx == LAST);
  assign byte_out = lane[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (strobe && !empty) begin
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end

  assert_idx_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe && !empty && idx == LAST) |=> (idx == '0));
  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe && empty) |=> $stable(idx));
endmodule

// File: rtl/nc_ovf_cross.sv
module nc_ovf_cross (
  input  logic wclk,
  input  logic wrst,
  input  logic drop,
  input  logic rclk,
  input  logic rrst,
  input  logic clear,
  output logic flag
);
  logic clr_tgl, clr_s1, clr_s2, clr_s3, clr_evt;
  logic ovf_core, f1;

  // Core domain: sticky set, cleared by a toggle edge from the read side.
  assign clr_evt = clr_s2 ^ clr_s3;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      clr_s1   <= 1'b0;
      clr_s2   <= 1'b0;
      clr_s3   <= 1'b0;
      ovf_core <= 1'b0;
    end else begin
      clr_s1 <= clr_tgl;
      clr_s2 <= clr_s1;
      clr_s3 <= clr_s2;
      if (drop) begin
        ovf_core <= 1'b1;
      end else if (clr_evt) begin
        ovf_core <= 1'b0;
      end
    end
  end

  // Read domain
  always_ff @(posedge rclk) begin
    if (rrst) begin
      clr_tgl <= 1'b0;
      f1      <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (clear) begin
        clr_tgl <= ~clr_tgl;
      end
      f1   <= ovf_core;
      flag <= f1;
    end
  end

  assert_ovf_hold_R8: assert property (@(posedge wclk) disable iff (wrst)
    (ovf_core && !clr_evt) |=> ovf_core);
  assert_ovf_clear_R9: assert property (@(posedge wclk) disable iff (wrst)
    (clr_evt && !drop) |=> !ovf_core);
endmodule

// File: rtl/nc_nonce_capture.sv
module nc_nonce_capture import nc_pkg::*; #(
  parameter int         NONCE_W    = 32,
  parameter int         PIPE_DEPTH = 125,
  parameter int         FIFO_AW    = 2,
  parameter capt_mode_e MODE       = CAPT_CORRECTED
) (
  input  logic               core_clk,
  input  logic               core_rst,
  input  logic               hash_en,
  input  logic               load_en,
  input  logic [NONCE_W-1:0] load_value,
  output logic [NONCE_W-1:0] issue_nonce,
  input  logic               match_in,
  input  logic               rd_clk,
  input  logic               rd_rst,
  input  logic               rd_strobe,
  output logic [BYTE_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic               ovf_flag,
  input  logic               ovf_clear
);
  logic               accept;
  logic               cap_valid;
  logic [NONCE_W-1:0] cap_data;
  logic               full, empty, pop;
  logic [NONCE_W-1:0] head_word;

  nc_nonce_gen #(.NONCE_W(NONCE_W), .PIPE_DEPTH(PIPE_DEPTH)) u_gen (
    .clk(core_clk), .rst(core_rst), .hash_en(hash_en), .load_en(load_en),
    .load_value(load_value), .nonce(issue_nonce), .accept(accept)
  );

  nc_capture #(.NONCE_W(NONCE_W), .PIPE_DEPTH(PIPE_DEPTH), .MODE(MODE)) u_cap (
    .clk(core_clk), .rst(core_rst), .match(match_in), .accept(accept),
    .nonce(issue_nonce), .cap_valid(cap_valid), .cap_data(cap_data)
  );

  nc_async_fifo #(.W(NONCE_W), .AW(FIFO_AW)) u_fifo (
    .wclk(core_clk), .wrst(core_rst), .wr_en(cap_valid), .wr_data(cap_data),
    .full(full), .rclk(rd_clk), .rrst(rd_rst), .rd_pop(pop),
    .rd_word(head_word), .empty(empty)
  );

  nc_byte_reader #(.W(NONCE_W)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .strobe(rd_strobe), .empty(empty),
    .word(head_word), .pop(pop), .byte_out(rd_data)
  );

  nc_ovf_cross u_ovf (
    .wclk(core_clk), .wrst(core_rst), .drop(cap_valid && full),
    .rclk(rd_clk), .rrst(rd_rst), .clear(ovf_clear), .flag(ovf_flag)
  );

  assign rd_valid = !empty;
endmodule

// File: tb/tb_nc_nonce_capture.sv
`timescale 1ns/100ps
module tb_nc_nonce_capture;
  import nc_pkg::*;

  localparam int DEPTH = 125;

  logic        core_clk = 1'b0, rd_clk = 1'b0;
  logic        core_rst, rd_rst, hash_en, load_en, match_in, rd_strobe, ovf_clear;
  logic [31:0] load_value, issue_nonce, issue_raw;
  logic [7:0]  rd_data, rd_data_raw;
  logic        rd_valid, rd_valid_raw, ovf_flag, ovf_flag_raw;

  int checks = 0;
  int errors = 0;

  always #2   core_clk = ~core_clk;   // 250 MHz
  always #6.5 rd_clk   = ~rd_clk;

  nc_nonce_capture #(.PIPE_DEPTH(DEPTH), .MODE(CAPT_CORRECTED)) dut (
    .core_clk(core_clk), .core_rst(core_rst), .hash_en(hash_en), .load_en(load_en),
    .load_value(load_value), .issue_nonce(issue_nonce), .match_in(match_in),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .rd_valid(rd_valid), .ovf_flag(ovf_flag), .ovf_clear(ovf_clear)
  );

  nc_nonce_capture #(.PIPE_DEPTH(DEPTH), .MODE(CAPT_RAW)) dut_raw (
    .core_clk(core_clk), .core_rst(core_rst), .hash_en(hash_en), .load_en(load_en),
    .load_value(load_value), .issue_nonce(issue_raw), .match_in(match_in),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_strobe(rd_strobe), .rd_data(rd_data_raw),
    .rd_valid(rd_valid_raw), .ovf_flag(ovf_flag_raw), .ovf_clear(ovf_clear)
  );

  function automatic logic [31:0] corr(input logic [31:0] n);
    return n - 32'(DEPTH);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic core_cycles(input int n);
    repeat (n) @(negedge core_clk);
  endtask

  task automatic rd_cycles(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic do_load(input logic [31:0] v);
    @(negedge core_clk);
    load_value = v;
    load_en    = 1'b1;
    @(negedge core_clk);
    load_en = 1'b0;
    check("R3 load value", issue_nonce, v);
  endtask

  task automatic fire(output logic [31:0] n);
    @(negedge core_clk);
    n        = issue_nonce;
    match_in = 1'b1;
    @(negedge core_clk);
    match_in = 1'b0;
  endtask

  task automatic read_word(output logic [31:0] a, output logic [31:0] b);
    int waited = 0;
    a = '0;
    b = '0;
    @(negedge rd_clk);
    while (!(rd_valid && rd_valid_raw) && waited < 60) begin
      @(negedge rd_clk);
      waited++;
    end
    check("R7 entry becomes visible", {31'd0, rd_valid && rd_valid_raw}, 32'd1);
    for (int i = 0; i < 4; i++) begin
      a[i*8 +: 8] = rd_data;
      b[i*8 +: 8] = rd_data_raw;
      rd_strobe = 1'b1;
      @(negedge rd_clk);
      rd_strobe = 1'b0;
    end
  endtask

  initial begin
    logic [31:0] n, a, b;
    logic [31:0] ns [5];
    core_rst = 1'b1; rd_rst = 1'b1; hash_en = 1'b0; load_en = 1'b0;
    load_value = '0; match_in = 1'b0; rd_strobe = 1'b0; ovf_clear = 1'b0;
    void'($urandom(32'd7177));

    rd_cycles(4);
    @(negedge core_clk); core_rst = 1'b0;
    @(negedge rd_clk);   rd_rst   = 1'b0;
    @(negedge core_clk);
    check("R1 nonce after reset", issue_nonce, 32'd0);
    check("R1 valid after reset", {31'd0, rd_valid}, 32'd0);
    check("R1 overflow after reset", {31'd0, ovf_flag}, 32'd0);

    // R2 counting and holding
    hash_en = 1'b1;
    n = issue_nonce;
    @(negedge core_clk);
    check("R2 step", issue_nonce, n + 32'd1);
    hash_en = 1'b0;
    n = issue_nonce;
    core_cycles(3);
    check("R2 hold", issue_nonce, n);
    hash_en = 1'b1;
    n = issue_nonce;
    core_cycles(5);
    check("R2 resume", issue_nonce, n + 32'd5);
    check("R2 both instances agree", issue_raw, issue_nonce);

    // R4 / R5 / R6 directed
    do_load(32'h1234_5678);
    core_cycles(DEPTH + 3);
    fire(n);
    read_word(a, b);
    check("R4 corrected value", a, corr(n));
    check("R5 raw value", b, n);
    check("R6 pop after four bytes", {31'd0, rd_valid}, 32'd0);

    // R3 blanking boundary: last blanked cycle
    do_load(32'hA5A5_0000);
    core_cycles(DEPTH - 2);
    fire(n);
    core_cycles(10);
    rd_cycles(8);
    check("R3 match inside blank ignored", {31'd0, rd_valid}, 32'd0);
    check("R3 raw match inside blank ignored", {31'd0, rd_valid_raw}, 32'd0);

    // R3 first accepted cycle
    do_load(32'h0BAD_F00D);
    core_cycles(DEPTH - 1);
    fire(n);
    check("R3 accepted nonce at boundary", n, 32'h0BAD_F00D + 32'(DEPTH));
    read_word(a, b);
    check("R3 first accepted corrected", a, 32'h0BAD_F00D);
    check("R3 first accepted raw", b, n);

    // R11 wrap below zero
    do_load(32'hFFFF_FFF0);
    core_cycles(DEPTH + 1);
    fire(n);
    read_word(a, b);
    check("R11 wrap corrected", a, corr(n));
    check("R11 wrap raw", b, n);

    // R7 strobes on empty queue are ignored
    for (int i = 0; i < 3; i++) begin
      @(negedge rd_clk); rd_strobe = 1'b1;
      @(negedge rd_clk); rd_strobe = 1'b0;
    end
    check("R7 empty stays empty", {31'd0, rd_valid}, 32'd0);
    do_load(32'h0102_0304);
    core_cycles(DEPTH + 7);
    fire(n);
    read_word(a, b);
    check("R7 byte order intact after idle strobes", a, corr(n));

    // R8 / R10 overflow and order
    do_load(32'h5000_0000);
    core_cycles(DEPTH);
    for (int i = 0; i < 5; i++) begin
      fire(ns[i]);
      core_cycles(3);
    end
    rd_cycles(10);
    check("R8 overflow set", {31'd0, ovf_flag}, 32'd1);
    check("R8 overflow set raw", {31'd0, ovf_flag_raw}, 32'd1);
    for (int i = 0; i < 4; i++) begin
      read_word(a, b);
      check("R10 order corrected", a, corr(ns[i]));
      check("R10 order raw", b, ns[i]);
    end
    rd_cycles(6);
    check("R8 fifth match dropped", {31'd0, rd_valid}, 32'd0);
    check("R8 overflow sticky", {31'd0, ovf_flag}, 32'd1);

    // R9 clear
    @(negedge rd_clk); ovf_clear = 1'b1;
    @(negedge rd_clk); ovf_clear = 1'b0;
    rd_cycles(10);
    check("R9 overflow cleared", {31'd0, ovf_flag}, 32'd0);
    check("R9 overflow cleared raw", {31'd0, ovf_flag_raw}, 32'd0);

    // Random rounds
    for (int r = 0; r < 12; r++) begin
      do_load($urandom);
      core_cycles(DEPTH - 1 + int'($urandom % 40));
      fire(n);
      read_word(a, b);
      check("R4 random corrected", a, corr(n));
      check("R5 random raw", b, n);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge core_clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule